// File: doc/BRIEF.md
# Convolutional Byte De-interleaver

This block undoes a convolutional byte interleave of depth 12 with a unit branch delay of 17 bytes. It works on a stream of aligned 204-byte blocks. Bytes arrive with a valid strobe and a start-of-block marker. A commutator steps through twelve delay branches, one branch for each valid byte. Branch j holds a byte for 17 × (11 − j) visits of that branch. Branch 0 is therefore the longest, and the last branch passes the byte straight through.

The marker that comes with a valid byte always puts that byte into branch 0. Any later marker pulls the commutator back to branch 0, so the alignment recovers after a resynchronization upstream. The marker is carried through branch 0 next to the data. It leaves the block on the de-interleaved sync byte, 11 × 204 valid bytes after it entered.

Each branch is a circular buffer of plain storage with no reset. It reads as zero until it has been written once all the way round. The `filled` output goes high once the longest branch has been primed this way.

Top module: `conv_deinterleaver`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, so there is one output byte for each accepted input byte.
- R2: With no marker, the k-th valid byte after a marker uses branch k mod 12. The commutator moves only on valid bytes.
- R3: A valid byte that carries `in_sob` is sent through branch 0, and the byte after it goes through branch 1. This holds wherever the commutator stood before.
- R4: A byte written into branch j comes out on the 17 × (11 − j)-th later visit of branch j. A byte in branch 11 comes out on the next cycle.
- R5: `out_sob` is high only with `out_valid`, and only for a byte that entered through branch 0 carrying a marker. In an aligned stream this is 2244 valid bytes after entry.
- R6: Until a branch has been written 17 × (11 − j) times since reset, its visits output the byte value 0x00 with no marker.
- R7: `filled` is low from reset and rises after the 187th write to branch 0. After that it stays high until reset.
- R8: While reset is low, and right after it is released, `out_valid`, `out_sob`, `filled` and `out_data` are all 0.
- R9: `in_sob` has no effect when `in_valid` is low. The commutator, the buffers and the outputs carry on as if the marker were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sob | input | 1 | Input byte is the first byte of a block |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sob | output | 1 | Output byte is a de-interleaved block start |
| out_data | output | 8 | Output byte |
| filled | output | 1 | Longest branch has been primed once |

## Verification
Every output is due one clock after the valid input that produces it. The branch delay counts visits to the branch, not cycles, so an idle cycle moves no result. The bench runs a queue-based model in step with its stimulus. It drives a byte on a falling edge and works out in that same step what the registers will show after the next rising edge. It compares those values on the following falling edge, so `out_valid`, `filled`, and (when valid) `out_data` and `out_sob` are checked on every cycle. Along the way the stimulus covers idle gaps, stray markers on idle cycles and a resynchronization in mid-block.

// File: rtl/deint_pkg.sv
package deint_pkg;

  // Number of entries held in branch j of a depth x unit convolutional de-interleaver.
  function automatic int branch_len(input int depth, input int unit, input int j);
    return unit * (depth - 1 - j);
  endfunction

  // Pointer width for a buffer of len entries (at least one bit).
  function automatic int ptr_bits(input int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/deint_commutator.sv
module deint_commutator #(
  parameter int DEPTH = 12,
  parameter int SW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sob,
  output logic [SW-1:0] sel
);

  logic [SW-1:0] cnt_q, cnt_d;

  // The marker only counts when it comes with a valid byte.
  always_comb begin
    sel = (in_valid && in_sob) ? '0 : cnt_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      if (sel == SW'(DEPTH - 1)) cnt_d = '0;
      else                       cnt_d = sel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (in_valid) cnt_q <= cnt_d;
  end

  AST_RESYNC_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sob) |=> (cnt_q == SW'(1 % DEPTH))); // R3

  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sob && cnt_q == SW'(DEPTH - 1)) |=> (cnt_q == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q)); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sob && cnt_q < SW'(DEPTH - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/deint_branch.sv
module deint_branch #(
  parameter int LEN = 17,
  parameter int W   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] raw,
  output logic         primed
);

  localparam int PW = deint_pkg::ptr_bits(LEN);

  logic [W-1:0]  mem [LEN];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          wrap_q, wrap_d;

  always_comb begin
    ptr_d  = ptr_q;
    wrap_d = wrap_q;
    if (en) begin
      if (ptr_q == PW'(LEN - 1)) begin
        ptr_d  = '0;
        wrap_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (en) begin
      ptr_q  <= ptr_d;
      wrap_q <= wrap_d;
    end
  end

  // Storage array: no reset, write-enabled on the branch's own visits.
  always_ff @(posedge clk) begin
    if (en) mem[ptr_q] <= din;
  end

  // Oldest entry sits at the current pointer; it is replaced in the same visit.
  assign raw    = mem[ptr_q];
  assign primed = wrap_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ptr_q)); // R2

  AST_PRIME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> wrap_q); // R6

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ptr_q < PW'(LEN))); // R4

endmodule

// File: rtl/deint_outmux.sv
module deint_outmux #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8,
  parameter int SW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [SW-1:0]               sel,
  input  logic [DEPTH-1:0][WIDTH:0]   rd_bus,
  output logic                        out_valid,
  output logic                        out_sob,
  output logic [WIDTH-1:0]            out_data
);

  logic [WIDTH:0]   pick;
  logic             valid_d, sob_d;
  logic [WIDTH-1:0] data_d;

  always_comb begin
    pick    = rd_bus[sel];
    valid_d = in_valid;
    sob_d   = in_valid & pick[WIDTH];
    data_d  = in_valid ? pick[WIDTH-1:0] : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_d;
      out_sob   <= sob_d;
      out_data  <= data_d;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1

  AST_SOB_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_sob |-> out_valid); // R5

  AST_SOB_ONLY_BRANCH0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel != '0) |=> !out_sob); // R5

endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver #(
  parameter int DEPTH = 12,
  parameter int UNIT  = 17,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sob,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic             out_sob,
  output logic [WIDTH-1:0] out_data,
  output logic             filled
);

  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = WIDTH + 1;

  logic [SW-1:0]              sel;
  logic [EW-1:0]              wr_ent;
  logic [DEPTH-1:0]           wr_en;
  logic [DEPTH-1:0]           primed;
  logic [DEPTH-1:0][EW-1:0]   rd_bus;

  assign wr_ent = {in_valid & in_sob, in_data};

  deint_commutator #(.DEPTH(DEPTH), .SW(SW)) u_comm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sob   (in_sob),
    .sel      (sel)
  );

  for (genvar j = 0; j < DEPTH; j++) begin : g_br
    localparam int LEN = deint_pkg::branch_len(DEPTH, UNIT, j);
    assign wr_en[j] = in_valid && (sel == SW'(j));
    if (LEN == 0) begin : g_pass
      assign primed[j] = 1'b1;
      assign rd_bus[j] = wr_ent;
    end else begin : g_fifo
      logic [EW-1:0] raw;
      deint_branch #(.LEN(LEN), .W(EW)) u_branch (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wr_en[j]),
        .din    (wr_ent),
        .raw    (raw),
        .primed (primed[j])
      );
      assign rd_bus[j] = primed[j] ? raw : '0;
    end
  end

  assign filled = primed[0];

  deint_outmux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SW(SW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sel       (sel),
    .rd_bus    (rd_bus),
    .out_valid (out_valid),
    .out_sob   (out_sob),
    .out_data  (out_data)
  );

  AST_FILLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled); // R7

  AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) == (in_valid ? 1 : 0)); // R2

  AST_UNPRIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed[sel]) |=> (out_data == '0 && !out_sob)); // R6

endmodule

// File: tb/sim_conv_deinterleaver.sv
module sim_conv_deinterleaver;

  localparam int DEPTH = 12;
  localparam int UNIT  = 17;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sob;
  logic [7:0] in_data;
  logic       out_valid, out_sob, filled;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  conv_deinterleaver u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob), .in_data(in_data),
    .out_valid(out_valid), .out_sob(out_sob), .out_data(out_data), .filled(filled)
  );

  typedef logic [8:0] ent_t;
  ent_t bq [DEPTH][$];

  int   n_checks = 0;
  int   n_fail   = 0;
  int   mcnt     = 0;
  int   w0       = 0;
  bit   stray    = 0;
  bit   phase_b  = 0;
  logic       e_valid, e_sob, e_filled;
  logic [7:0] e_data;
  string      e_tag;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model: compute what the outputs must show after the next rising edge.
  task automatic apply(input bit v, input bit sob, input logic [7:0] d);
    int   j;
    int   len;
    ent_t res;
    in_valid = v; in_sob = sob; in_data = d;
    e_valid = v;
    e_filled = e_filled;
    if (!v) begin
      if (sob) stray = 1;
      return;
    end
    j   = sob ? 0 : mcnt;
    mcnt = (j + 1) % DEPTH;
    len = UNIT * (DEPTH - 1 - j);
    e_tag = phase_b ? "R3" : "R2";
    if (stray) e_tag = "R9";
    stray = 0;
    if (len == 0) begin
      res = {sob, d};
      e_tag = "R4";
    end else begin
      bq[j].push_back({sob, d});
      if (bq[j].size() > len) res = bq[j].pop_front();
      else begin
        res = '0;
        e_tag = "R6";
      end
    end
    if (j == 0) w0++;
    e_data   = res[7:0];
    e_sob    = res[8];
    e_filled = (w0 >= UNIT * (DEPTH - 1));
  endtask

  task automatic compare();
    chk("R1 out_valid", out_valid, e_valid);
    chk("R7 filled", filled, e_filled);
    if (e_valid) begin
      chk({e_tag, " out_data"}, out_data, e_data);
      chk("R5 out_sob", out_sob, e_sob);
    end else begin
      chk("R5 out_sob idle", out_sob, 0);
    end
  endtask

  task automatic step(input int pos_mod, inout int pos);
    bit v;
    bit sob;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = (lfsr[2:0] != 3'd0);
    sob = v ? (pos == 0) : lfsr[5];
    @(negedge clk);
    compare();
    apply(v, sob, lfsr[15:8] ^ 8'(pos));
    if (v) pos = (pos + 1) % pos_mod;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int pos;
    rst_n = 1'b0; in_valid = 0; in_sob = 0; in_data = '0;
    e_valid = 0; e_sob = 0; e_filled = 0; e_data = '0; e_tag = "R2";
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid", out_valid, 0);
    chk("R8 out_sob", out_sob, 0);
    chk("R8 out_data", out_data, 0);
    chk("R8 filled", filled, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after release", out_valid, 0);
    chk("R8 filled after release", filled, 0);
    // Aligned stream with idle gaps and stray markers on idle cycles
    pos = 0;
    for (int c = 0; c < 3600; c++) step(204, pos);
    // Resynchronize mid-block
    phase_b = 1;
    pos = 0;
    for (int c = 0; c < 77; c++) step(500, pos);
    pos = 0;
    for (int c = 0; c < 1400; c++) step(204, pos);
    @(negedge clk);
    compare();
    apply(0, 0, 8'h00);
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule